// File: doc/BRIEF.md
# I2C Master Command Engine

This block is a single-master I2C controller steered by a compact command and status interface rather than by a byte-level program. Software writes an 8-bit data register, then issues a 3-bit command (continue, start, stop). The engine produces the start, repeated start, address, data, acknowledge and stop phases on open-drain SCL and SDA. It then halts at a fixed handshake point, raises a pending flag and reports a 3-bit state code that tells software what it may do next.

A read needs few commands. When an address with the read bit set is acknowledged, the engine clocks in the first data byte without being asked. A later continue acknowledges the held byte and fetches the next one. A stop instead NAKs the held byte and then ends the transfer. The SCL rate comes from a divider input that sets the length of a quarter bit period.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, pending is 1, the state code is 0 (idle), and neither SCL nor SDA is pulled low.
- R2: Command bits are cmd[0] continue, cmd[1] start, cmd[2] stop, with priority stop > start > continue. A command is taken only while pending is 1 and only if it applies to the current state code; otherwise it is ignored. Data-register writes are ignored while pending is 0.
- R3: Start from state 0 sends a start condition, then the data register MSB first as the address byte. If the slave ACKs and bit 0 is 0, the engine stops in state 2 (ready to transmit). If the slave NAKs, it stops in state 3.
- R4: If an address with bit 0 = 1 is ACKed, the engine reads one byte MSB first with no further command. It then stops in state 1 (byte received), with the byte on data_out.
- R5: In state 2, continue sends the data register MSB first. If the slave ACKs, the engine returns to state 2.
- R6: If the slave NAKs a data byte, the engine stops in state 4 (data NAKed).
- R7: In state 1, continue drives SDA low in the ninth slot (ACK) and reads the next byte. Stop leaves SDA released in that slot (NAK) and then issues a stop condition.
- R8: Start in states 2, 3 or 4 issues a repeated start without a stop. In state 1 it first NAKs the held byte. In every case the data register is then sent as the address.
- R9: Stop in states 2, 3 or 4 (and after the NAK slot in state 1) issues a stop condition. The engine then waits in state 0 with both lines released.
- R10: Each quarter of an SCL bit lasts clk_div+1 clock cycles, so SCL is high for 2·(clk_div+1) cycles in each bit.
- R11: SDA changes while SCL is high only for a start or stop condition. Received bits and ACKs are sampled while SCL is high. While pending, both lines hold their levels, and SCL stays low in states 1 to 4.
- R12: A data write and a command in the same cycle act as if the write came first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | DIV_W | Quarter-bit period minus one, in clock cycles |
| data_we | input | 1 | Write data_in into the data register |
| data_in | input | 8 | Address or transmit byte |
| cmd_valid | input | 1 | Command strobe |
| cmd | input | 3 | [0] continue, [1] start, [2] stop |
| data_out | output | 8 | Data register (received byte in state 1) |
| pending | output | 1 | Engine waiting for a command |
| state_code | output | 3 | 0 idle, 1 byte received, 2 ready to transmit, 3 address NAK, 4 data NAK |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
A wrong sequencing state shows on the bus within one quarter bit. An extra or missing bit moves every later ACK slot, so the slave model NAKs or misreads the next byte. At the next handshake point the state code or data_out is then wrong. A fault in the SCL phase order shows as a spurious start or stop event, which the bus monitor counts. While the engine waits, any bus movement is flagged in the same clock cycle. A broken divider shows as a wrong SCL high time on the very next bit.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [1:0] {BOP_START, BOP_STOP, BOP_BIT} bop_e;
  typedef enum logic [2:0] {ST_HOLD, ST_START, ST_TX, ST_RX, ST_ACKO, ST_STOP} cst_e;
  typedef enum logic [1:0] {NX_READ, NX_STOP, NX_RSTART} nxt_e;
  localparam int CMD_CONT  = 0;
  localparam int CMD_START = 1;
  localparam int CMD_STOP  = 2;
  localparam logic [2:0] CODE_IDLE  = 3'd0;
  localparam logic [2:0] CODE_RXRDY = 3'd1;
  localparam logic [2:0] CODE_TXRDY = 3'd2;
  localparam logic [2:0] CODE_ANAK  = 3'd3;
  localparam logic [2:0] CODE_DNAK  = 3'd4;
endpackage

// File: rtl/i2cm_qtick.sv
module i2cm_qtick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick = run && !load && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)     cnt_d = div;
    else if (run) cnt_d = (cnt_q == '0) ? div : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R10: a quarter never ends on two consecutive cycles unless the divider is zero
  a_r10_quarter_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (div != '0) && $stable(div)) |=> !tick);
endmodule

// File: rtl/i2cm_bitengine.sv
module i2cm_bitengine import i2cm_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             go,
  input  bop_e             kind,
  input  logic             wbit,
  input  logic             sda_in,
  output logic             busy,
  output logic             done,
  output logic             rbit,
  output logic             scl_oe,
  output logic             sda_oe
);
  logic       busy_q, busy_d, done_q, done_d, rbit_q, rbit_d;
  logic       wbit_q, wbit_d, scl_q, scl_d, sda_q, sda_d;
  logic [1:0] q_q, q_d;
  bop_e       kind_q, kind_d;
  logic       tick, start_op;

  // {scl, sda} levels for each quarter of an operation
  function automatic logic [1:0] lvl(bop_e k, logic [1:0] q, logic b, logic scl_now);
    logic [1:0] r;
    case (k)
      BOP_START: case (q)
                   2'd0: r = {scl_now, 1'b1};
                   2'd1: r = 2'b11;
                   2'd2: r = 2'b10;
                   default: r = 2'b00;
                 endcase
      BOP_STOP:  case (q)
                   2'd0: r = 2'b00;
                   2'd1: r = 2'b10;
                   default: r = 2'b11;
                 endcase
      default:   r = {(q == 2'd1) || (q == 2'd2), b};
    endcase
    return r;
  endfunction

  assign start_op = go && !busy_q;

  i2cm_qtick #(.DIV_W(DIV_W)) u_qtick (
    .clk(clk), .rst_n(rst_n), .load(start_op), .run(busy_q), .div(div), .tick(tick)
  );

  always_comb begin
    busy_d = busy_q; q_d = q_q; kind_d = kind_q; wbit_d = wbit_q;
    scl_d = scl_q; sda_d = sda_q; rbit_d = rbit_q; done_d = 1'b0;
    if (start_op) begin
      busy_d = 1'b1; q_d = 2'd0; kind_d = kind; wbit_d = wbit;
      {scl_d, sda_d} = lvl(kind, 2'd0, wbit, scl_q);
    end else if (busy_q && tick) begin
      if (q_q == 2'd3) begin
        busy_d = 1'b0; done_d = 1'b1;
      end else begin
        q_d = q_q + 2'd1;
        {scl_d, sda_d} = lvl(kind_q, q_q + 2'd1, wbit_q, scl_q);
        if (q_q == 2'd1) rbit_d = sda_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; q_q <= 2'd0; kind_q <= BOP_BIT; wbit_q <= 1'b1;
      scl_q <= 1'b1; sda_q <= 1'b1; rbit_q <= 1'b1; done_q <= 1'b0;
    end else begin
      busy_q <= busy_d; q_q <= q_d; kind_q <= kind_d; wbit_q <= wbit_d;
      scl_q <= scl_d; sda_q <= sda_d; rbit_q <= rbit_d; done_q <= done_d;
    end
  end

  assign busy   = busy_q;
  assign done   = done_q;
  assign rbit   = rbit_q;
  assign scl_oe = !scl_q;
  assign sda_oe = !sda_q;

  // R11: inside a data or ACK bit, SDA holds while SCL stays high
  a_r11_sda_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q) && (kind_q == BOP_BIT) && scl_q && $past(scl_q)) |-> $stable(sda_q));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master import i2cm_pkg::*; #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             data_we,
  input  logic [7:0]       data_in,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd,
  output logic [7:0]       data_out,
  output logic             pending,
  output logic [2:0]       state_code,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  localparam int BITS   = 8;
  localparam int CNT_W  = $clog2(BITS + 1);
  localparam logic [CNT_W-1:0] LAST_DATA = CNT_W'(BITS - 1);
  localparam logic [CNT_W-1:0] ACK_SLOT  = CNT_W'(BITS);

  logic [1:0] rsync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_i = rsync[1];

  cst_e             st_q, st_d;
  nxt_e             nx_q, nx_d;
  bop_e             kind_q, kind_d;
  logic [2:0]       code_q, code_d;
  logic [BITS-1:0]  dreg_q, dreg_d, wdat;
  logic [CNT_W-1:0] bcnt_q, bcnt_d;
  logic             isaddr_q, isaddr_d, rw_q, rw_d, go_q, go_d, wbit_q, wbit_d;
  logic             bbusy, bdone, rbit;

  i2cm_bitengine #(.DIV_W(DIV_W)) u_bits (
    .clk(clk), .rst_n(rst_i), .div(clk_div), .go(go_q), .kind(kind_q), .wbit(wbit_q),
    .sda_in(sda_in), .busy(bbusy), .done(bdone), .rbit(rbit), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  assign pending = (st_q == ST_HOLD);

  always_comb begin
    st_d = st_q; nx_d = nx_q; kind_d = kind_q; code_d = code_q; bcnt_d = bcnt_q;
    isaddr_d = isaddr_q; rw_d = rw_q; wbit_d = wbit_q; go_d = 1'b0;
    wdat   = (data_we && pending) ? data_in : dreg_q;
    dreg_d = wdat;
    if (pending && cmd_valid) begin
      case (code_q)
        CODE_IDLE: if (cmd[CMD_START]) begin
          st_d = ST_START; go_d = 1'b1; kind_d = BOP_START;
        end
        CODE_RXRDY: if (|cmd) begin
          st_d = ST_ACKO; go_d = 1'b1; kind_d = BOP_BIT;
          if (cmd[CMD_STOP])       begin wbit_d = 1'b1; nx_d = NX_STOP;   end
          else if (cmd[CMD_START]) begin wbit_d = 1'b1; nx_d = NX_RSTART; end
          else                     begin wbit_d = 1'b0; nx_d = NX_READ;   end
        end
        default: begin
          if (cmd[CMD_STOP]) begin
            st_d = ST_STOP; go_d = 1'b1; kind_d = BOP_STOP;
          end else if (cmd[CMD_START]) begin
            st_d = ST_START; go_d = 1'b1; kind_d = BOP_START;
          end else if (cmd[CMD_CONT] && (code_q == CODE_TXRDY)) begin
            st_d = ST_TX; go_d = 1'b1; kind_d = BOP_BIT; wbit_d = wdat[BITS-1];
            bcnt_d = '0; isaddr_d = 1'b0;
          end
        end
      endcase
    end else if (bdone) begin
      case (st_q)
        ST_START: begin
          st_d = ST_TX; isaddr_d = 1'b1; rw_d = dreg_q[0]; bcnt_d = '0;
          go_d = 1'b1; kind_d = BOP_BIT; wbit_d = dreg_q[BITS-1];
        end
        ST_TX: if (bcnt_q == ACK_SLOT) begin
          if (rbit) begin
            st_d = ST_HOLD; code_d = isaddr_q ? CODE_ANAK : CODE_DNAK;
          end else if (isaddr_q && rw_q) begin
            st_d = ST_RX; bcnt_d = '0; go_d = 1'b1; kind_d = BOP_BIT; wbit_d = 1'b1;
          end else begin
            st_d = ST_HOLD; code_d = CODE_TXRDY;
          end
        end else begin
          dreg_d = {dreg_q[BITS-2:0], rbit}; bcnt_d = bcnt_q + 1'b1;
          go_d = 1'b1; kind_d = BOP_BIT;
          wbit_d = (bcnt_q == LAST_DATA) ? 1'b1 : dreg_q[BITS-2];
        end
        ST_RX: begin
          dreg_d = {dreg_q[BITS-2:0], rbit};
          if (bcnt_q == LAST_DATA) begin
            st_d = ST_HOLD; code_d = CODE_RXRDY;
          end else begin
            bcnt_d = bcnt_q + 1'b1; go_d = 1'b1; kind_d = BOP_BIT; wbit_d = 1'b1;
          end
        end
        ST_ACKO: begin
          go_d = 1'b1;
          case (nx_q)
            NX_STOP:   begin st_d = ST_STOP;  kind_d = BOP_STOP;  end
            NX_RSTART: begin st_d = ST_START; kind_d = BOP_START; end
            default:   begin st_d = ST_RX; kind_d = BOP_BIT; wbit_d = 1'b1; bcnt_d = '0; end
          endcase
        end
        ST_STOP: begin st_d = ST_HOLD; code_d = CODE_IDLE; end
        default: st_d = ST_HOLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      st_q <= ST_HOLD; nx_q <= NX_READ; kind_q <= BOP_BIT; code_q <= CODE_IDLE;
      dreg_q <= '0; bcnt_q <= '0; isaddr_q <= 1'b0; rw_q <= 1'b0; go_q <= 1'b0; wbit_q <= 1'b1;
    end else begin
      st_q <= st_d; nx_q <= nx_d; kind_q <= kind_d; code_q <= code_d;
      dreg_q <= dreg_d; bcnt_q <= bcnt_d; isaddr_q <= isaddr_d; rw_q <= rw_d;
      go_q <= go_d; wbit_q <= wbit_d;
    end
  end

  assign data_out   = dreg_q;
  assign state_code = code_q;

  // R2: while waiting for software the bit sequencer is quiet
  a_r2_hold_engine_quiet: assert property (@(posedge clk) disable iff (!rst_i)
    pending |-> !bbusy);
  // R11: mid-transfer waits keep SCL low
  a_r11_scl_held_low: assert property (@(posedge clk) disable iff (!rst_i)
    (pending && (code_q != CODE_IDLE)) |-> scl_oe);
  // R9: the end of a stop lands in idle with the bus released
  a_r9_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_i)
    ($past(st_q == ST_STOP) && $past(bdone)) |-> (pending && (code_q == CODE_IDLE) && !scl_oe && !sda_oe));
  // R7: the acknowledge slot for a held byte drives SDA low only when reading on
  a_r7_ack_level: assert property (@(posedge clk) disable iff (!rst_i)
    ((st_q == ST_ACKO) && bbusy) |-> (sda_oe == (nx_q == NX_READ)));
endmodule

// File: tb/i2c_cmd_master_tb.sv
module i2c_cmd_master_tb;
  localparam logic [6:0] SLV = 7'h2A;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] clk_div = 16'd3;
  logic        data_we = 1'b0, cmd_valid = 1'b0;
  logic [7:0]  data_in = 8'h00;
  logic [2:0]  cmd = 3'b000;
  logic [7:0]  data_out;
  logic        pending, scl_oe, sda_oe, sda_in;
  logic [2:0]  state_code;
  logic        slv_low = 1'b0;
  logic        scl, sda;

  always #5 clk = !clk;

  assign scl    = !scl_oe;
  assign sda    = !(sda_oe || slv_low);
  assign sda_in = sda;

  i2c_cmd_master u_dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .data_we(data_we), .data_in(data_in),
    .cmd_valid(cmd_valid), .cmd(cmd), .data_out(data_out), .pending(pending),
    .state_code(state_code), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  int vectors = 0, errors = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural slave, bus event monitor and per-clock hold check
  logic [7:0] rd_mem [4] = '{8'h96, 8'h0F, 8'hC3, 8'h5A};
  logic [7:0] got_q [$];
  bit         ack_log [$];
  int  n_start = 0, n_stop = 0, bitn = 0, mode = 0, nxt = 0, ridx = 0;
  int  hi_cnt = 0, last_hi = 0;
  logic [7:0] sh = 8'h00, txb = 8'h00;
  logic pscl = 1'b1, psda = 1'b1, ppend = 1'b0, pscl_oe = 1'b0, psda_oe = 1'b0;

  always @(negedge clk) begin
    if (!rst_n) begin
      mode = 0; bitn = 0; slv_low <= 1'b0;
    end else begin
      // R11: nothing on the bus moves while the engine waits
      if (pending && ppend)
        check((scl_oe == pscl_oe) && (sda_oe == psda_oe), "R11 bus hold",
              {scl_oe, sda_oe}, {pscl_oe, psda_oe});
      if (scl) hi_cnt++;
      else if (pscl) begin last_hi = hi_cnt; hi_cnt = 0; end
      if (pscl && scl && psda && !sda) begin
        n_start++; mode = 1; bitn = 0; slv_low <= 1'b0;
      end else if (pscl && scl && !psda && sda) begin
        n_stop++; mode = 0; bitn = 0; slv_low <= 1'b0;
      end else if (!pscl && scl) begin
        if (bitn < 8) sh = {sh[6:0], sda};
        else if (mode == 3) begin ack_log.push_back(sda); nxt = sda ? 0 : 3; end
        bitn++;
      end else if (pscl && !scl) begin
        if (bitn == 8) begin
          if (mode == 1) begin
            if (sh[7:1] == SLV) begin slv_low <= 1'b1; nxt = sh[0] ? 3 : 2; end
            else nxt = 0;
          end else if (mode == 2) begin
            got_q.push_back(sh);
            slv_low <= (sh != 8'hEE); nxt = (sh != 8'hEE) ? 2 : 0;
          end else if (mode == 3) slv_low <= 1'b0;
        end else if (bitn == 9) begin
          bitn = 0; mode = nxt; slv_low <= 1'b0;
          if (mode == 3) begin
            txb = rd_mem[ridx % 4]; ridx++; slv_low <= !txb[7];
          end
        end else if ((bitn >= 1) && (bitn <= 7) && (mode == 3)) slv_low <= !txb[7 - bitn];
      end
    end
    pscl = scl; psda = sda; ppend = pending; pscl_oe = scl_oe; psda_oe = sda_oe;
  end

  task automatic issue(input logic we, input logic [7:0] d, input logic [2:0] c);
    @(negedge clk);
    data_we = we; data_in = d; cmd_valid = (c != 3'b000); cmd = c;
    @(negedge clk);
    data_we = 1'b0; cmd_valid = 1'b0; cmd = 3'b000;
  endtask

  task automatic wait_pend(input string req);
    int n = 0;
    while (!pending && n < 20000) begin @(negedge clk); n++; end
    if (!pending) check(1'b0, {req, " handshake timeout"}, 0, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    check(pending == 1'b1, "R1 pending", pending, 1);
    check(state_code == 3'd0, "R1 code", state_code, 0);
    check(!scl_oe && !sda_oe, "R1 lines", {scl_oe, sda_oe}, 0);

    // R2: continue in idle is ignored
    issue(1'b0, 8'h00, 3'b001);
    repeat (40) @(negedge clk);
    check(pending && state_code == 3'd0, "R2 idle continue", state_code, 0);
    check(n_start == 0, "R2 no bus activity", n_start, 0);

    // R3 write address; R2 data/stop during busy ignored
    issue(1'b1, 8'h54, 3'b010);
    issue(1'b1, 8'hFF, 3'b100);
    wait_pend("R3");
    check(state_code == 3'd2, "R3 addr ack write", state_code, 2);
    check(data_out == 8'h54, "R2 busy write ignored", data_out, 8'h54);
    check(n_stop == 0, "R2 busy stop ignored", n_stop, 0);

    // R12 + R5: load and continue in the same cycle
    issue(1'b1, 8'hA5, 3'b001);
    wait_pend("R5");
    check(state_code == 3'd2, "R5 data ack", state_code, 2);
    check(got_q.size() == 1 && got_q[0] == 8'hA5, "R12 same-cycle load", got_q[$], 8'hA5);
    check(last_hi == 8, "R10 scl high div3", last_hi, 8);

    issue(1'b1, 8'h3C, 3'b000);
    issue(1'b0, 8'h00, 3'b001);
    wait_pend("R5");
    check(state_code == 3'd2 && got_q[$] == 8'h3C, "R5 second byte", got_q[$], 8'h3C);

    // R6 data NAK
    issue(1'b1, 8'hEE, 3'b001);
    wait_pend("R6");
    check(state_code == 3'd4, "R6 data nak", state_code, 4);

    // R9 stop
    issue(1'b0, 8'h00, 3'b101);
    wait_pend("R9");
    check(state_code == 3'd0 && !scl_oe && !sda_oe, "R9 idle released", state_code, 0);
    check(n_stop == 1, "R9 stop seen", n_stop, 1);

    // R4 read with auto first byte, faster clock
    clk_div = 16'd1;
    issue(1'b1, 8'h55, 3'b010);
    wait_pend("R4");
    check(state_code == 3'd1, "R4 rx ready", state_code, 1);
    check(data_out == 8'h96, "R4 first byte", data_out, 8'h96);
    check(last_hi == 4, "R10 scl high div1", last_hi, 4);

    // R7 continue ACKs, stop NAKs
    issue(1'b0, 8'h00, 3'b001);
    wait_pend("R7");
    check(state_code == 3'd1 && data_out == 8'h0F, "R7 next byte", data_out, 8'h0F);
    check(ack_log.size() >= 1 && ack_log[0] == 1'b0, "R7 ack driven", ack_log[0], 0);
    issue(1'b0, 8'h00, 3'b100);
    wait_pend("R7");
    check(state_code == 3'd0 && ack_log.size() == 2 && ack_log[1] == 1'b1, "R7 nak then stop",
          ack_log.size(), 2);
    check(n_stop == 2, "R9 stop after read", n_stop, 2);

    // R3 address NAK
    issue(1'b1, 8'h60, 3'b010);
    wait_pend("R3");
    check(state_code == 3'd3, "R3 addr nak", state_code, 3);
    issue(1'b0, 8'h00, 3'b100);
    wait_pend("R9");
    check(state_code == 3'd0, "R9 stop after nak", state_code, 0);

    // R8 repeated starts
    issue(1'b1, 8'h54, 3'b010);
    wait_pend("R8");
    issue(1'b1, 8'h11, 3'b001);
    wait_pend("R8");
    check(got_q[$] == 8'h11, "R5 byte before restart", got_q[$], 8'h11);
    issue(1'b1, 8'h55, 3'b011);
    wait_pend("R8");
    check(state_code == 3'd1 && data_out == 8'hC3, "R8 restart read", data_out, 8'hC3);
    check(n_stop == 3 && n_start == 5, "R8 no stop between", n_start, 5);
    issue(1'b1, 8'h54, 3'b010);
    wait_pend("R8");
    check(state_code == 3'd2, "R8 restart from rx", state_code, 2);
    check(ack_log.size() == 3 && ack_log[2] == 1'b1, "R8 nak before restart", ack_log.size(), 3);
    issue(1'b0, 8'h00, 3'b100);
    wait_pend("R9");

    // R11: no spurious start/stop events across the run
    check(n_start == 6, "R11 start count", n_start, 6);
    check(n_stop == 4, "R11 stop count", n_stop, 4);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule